// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This engine moves a run of bytes from one memory region to another without the processor touching the data. Software loads a source pointer, a destination pointer, a byte count and a control word through a small register load port. It then sets the start bit. The engine asks for the bus with a hold request and waits for the grant. It then owns the bus and alternates two operations for each byte. The first reads from the source address into an internal holding register. The second writes that register to the destination address.

The source and destination pointers each step by one after every byte. Each has its own programmed direction, up or down. The count falls by one per byte. The copy keeps the bus as a single burst until one of three things ends it. The count reaching zero ends it with a one-cycle terminal-count pulse. An external end-of-process input ends it early, and so does an optional match: the byte just read equals a programmed compare value. When the copy ends, hold request drops, a done flag is set, and the final pointers and remaining count stay visible at the ports.

Top module: `m2m_copy_engine`

## Requirements
- R1: After reset, hold_req, mem_rd, mem_wr, tc and done are low, and src_ptr, dst_ptr and count_left are zero.
- R2: A load with cfg_sel=4 and cfg_wdata bit 0 set, made while idle, raises hold_req in the next cycle. No strobe is issued while hold_ack stays low. The first mem_rd cycle follows the clock edge that samples hold_ack high.
- R3: Each byte takes one mem_rd cycle at src_ptr, then in the next cycle one mem_wr cycle at dst_ptr. In that write cycle, mem_wdata is the byte read.
- R4: After each byte, src_ptr steps down by one if control bit 1 is set, otherwise up by one. dst_ptr does the same under control bit 2.
- R5: count_left (loaded with cfg_sel=2) drops by one per byte. When it reaches zero, tc is high for exactly one cycle, done is set and hold_req is low in that same cycle.
- R6: Once a copy has started, hold_req stays high until it ends, and successive writes are exactly two cycles apart.
- R7: If eop_in is high while the grant is being awaited, the copy ends with no transfer. If eop_in is high during a byte's read or write cycle, that byte is written and the copy then ends. In both cases tc stays low.
- R8: When control bit 3 is set and a byte read equals the compare byte (cfg_sel=3, low 8 bits), that byte is still written and the copy then ends, with tc low.
- R9: Register loads (cfg_sel 0 = source pointer, 1 = destination pointer) made while a copy is in progress have no effect.
- R10: A start with count_left zero sets done in the next cycle and never raises hold_req or a strobe.
- R11: After a copy ends, src_ptr, dst_ptr, count_left and done hold their values until the next start. The next start clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register load strobe |
| cfg_sel | input | 3 | Register select: 0 source, 1 destination, 2 count, 3 compare, 4 control |
| cfg_wdata | input | AW | Load data |
| hold_req | output | 1 | Bus hold request |
| hold_ack | input | 1 | Bus hold grant |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Read data, accepted in the read cycle |
| mem_wdata | output | DW | Write data |
| eop_in | input | 1 | External end-of-process |
| tc | output | 1 | Terminal-count pulse |
| done | output | 1 | Copy finished flag |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count_left | output | CW | Bytes remaining |

## Verification
A wrong holding register or a wrong pointer shows up at the very next write. The scoreboard compares that write's address and data against an independently computed copy. A counter or stop decision that is off by one shows as an extra or missing write, a missing or stray tc pulse, or wrong final pointers. These are all visible within two cycles of the faulty byte, and at the latest when done rises. A state machine that loses the burst breaks the two-cycle write spacing at once.

// File: rtl/m2m_copy_engine.sv
module m2m_copy_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          hold_req,
  input  logic          hold_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  input  logic          eop_in,
  output logic          tc,
  output logic          done,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count_left
);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_RD, S_WR} st_t;

  st_t          st;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] tmp_q, cmp_q;
  logic          src_dn, dst_dn, cmp_en;
  logic          stop_q, done_q, tc_q;

  wire idle   = (st == S_IDLE);
  wire cfg_ok = cfg_we && idle;
  wire go     = cfg_ok && (cfg_sel == 3'd4) && cfg_wdata[0];
  wire hit    = cmp_en && (mem_rdata == cmp_q);
  wire last   = (cnt_q == CW'(1));
  wire halt   = stop_q || eop_in;

  assign hold_req   = !idle;
  assign mem_rd     = (st == S_RD);
  assign mem_wr     = (st == S_WR);
  assign mem_addr   = mem_wr ? dst_q : src_q;
  assign mem_wdata  = tmp_q;
  assign tc         = tc_q;
  assign done       = done_q;
  assign src_ptr    = src_q;
  assign dst_ptr    = dst_q;
  assign count_left = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      tmp_q  <= '0;
      cmp_q  <= '0;
      src_dn <= 1'b0;
      dst_dn <= 1'b0;
      cmp_en <= 1'b0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (cfg_ok) begin
        case (cfg_sel)
          3'd0: src_q <= cfg_wdata;
          3'd1: dst_q <= cfg_wdata;
          3'd2: cnt_q <= cfg_wdata[CW-1:0];
          3'd3: cmp_q <= cfg_wdata[DW-1:0];
          3'd4: begin
            src_dn <= cfg_wdata[1];
            dst_dn <= cfg_wdata[2];
            cmp_en <= cfg_wdata[3];
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (go) begin
          stop_q <= 1'b0;
          done_q <= 1'b0;
          if (cnt_q == '0) done_q <= 1'b1;
          else             st     <= S_HOLD;
        end
        S_HOLD: begin
          if (eop_in) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (hold_ack) begin
            st <= S_RD;
          end
        end
        S_RD: begin
          tmp_q <= mem_rdata;
          if (eop_in || hit) stop_q <= 1'b1;
          st <= S_WR;
        end
        S_WR: begin
          src_q <= src_dn ? src_q - AW'(1) : src_q + AW'(1);
          dst_q <= dst_dn ? dst_q - AW'(1) : dst_q + AW'(1);
          cnt_q <= cnt_q - CW'(1);
          if (last) begin
            tc_q   <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (halt) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  // R6
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2
  first_rd_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(mem_wr)) |-> $past(hold_ack));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr) |-> (count_left == $past(count_left) - CW'(1)));

  // R5
  tc_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (done && !hold_req && count_left == '0));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr) |-> ((src_ptr == $past(src_ptr) + AW'(1)) || (src_ptr == $past(src_ptr) - AW'(1))));

endmodule

// File: tb/m2m_copy_engine_tb.sv
module m2m_copy_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        hold_req, hold_ack = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        eop_in = 1'b0;
  logic        tc, done;
  logic [15:0] src_ptr, dst_ptr, count_left;

  m2m_copy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .eop_in(eop_in),
    .tc(tc), .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count_left(count_left)
  );

  always #4 clk = ~clk;

  logic [7:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  initial forever begin
    @(posedge clk);
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  logic ack_gate = 1'b0;
  initial forever begin
    @(posedge clk);
    hold_ack <= hold_req && ack_gate;
  end

  int checks = 0, fails = 0;
  int tc_seen = 0, wr_seen = 0, prev_wr = -1, cyc = 0;
  logic [15:0] q_addr [$];
  logic [7:0]  q_data [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    if (tc) tc_seen++;
    if (mem_wr) begin
      wr_seen++;
      if (prev_wr >= 0) chk("R6 write spacing", cyc - prev_wr, 2);
      prev_wr = cyc;
      if (q_addr.size() == 0) chk("R3 unexpected write", 1, 0);
      else begin
        chk("R3 write addr", mem_addr, q_addr.pop_front());
        chk("R3 write data", mem_wdata, q_data.pop_front());
      end
    end
  end

  task automatic wr_cfg(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  logic [15:0] e_src, e_dst, e_cnt;

  task automatic plan(input logic [15:0] s, d, n, input bit sdn, ddn, men,
                      input logic [7:0] mb, input int lim);
    logic [7:0] b;
    e_src = s; e_dst = d; e_cnt = n;
    for (int i = 0; i < n; i++) begin
      b = mem[e_src[9:0]];
      q_addr.push_back(e_dst);
      q_data.push_back(b);
      e_src = sdn ? e_src - 16'd1 : e_src + 16'd1;
      e_dst = ddn ? e_dst - 16'd1 : e_dst + 16'd1;
      e_cnt = e_cnt - 16'd1;
      if (men && b == mb) break;
      if (lim > 0 && i + 1 == lim) break;
    end
  endtask

  task automatic run_copy(input logic [15:0] s, d, n, input bit sdn, ddn, men,
                          input logic [7:0] mb, input int eop_at, input int ack_wait,
                          input bit poke, input bit exp_tc);
    int k = 0;
    int t = 0;
    tc_seen = 0; prev_wr = -1;
    plan(s, d, n, sdn, ddn, men, mb, eop_at);
    wr_cfg(3'd0, s); wr_cfg(3'd1, d); wr_cfg(3'd2, n); wr_cfg(3'd3, {8'h00, mb});
    wr_cfg(3'd4, {12'h000, men, ddn, sdn, 1'b1});
    chk("R2 hold_req after start", hold_req, 1);
    chk("R11 done cleared by start", done, 0);
    for (int i = 0; i < ack_wait; i++) begin
      chk("R2 no read before grant", mem_rd, 0);
      @(negedge clk);
    end
    ack_gate = 1'b1;
    if (poke) begin
      wr_cfg(3'd0, 16'h0300);
      wr_cfg(3'd1, 16'h0380);
    end
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      if (!done) chk("R6 hold held during copy", hold_req, 1);
      if (mem_wr) begin
        k++;
        eop_in = (eop_at > 0 && k == eop_at);
      end else eop_in = 1'b0;
    end
    eop_in = 1'b0;
    ack_gate = 1'b0;
    chk("R5 done set", done, 1);
    chk("R5 hold released", hold_req, 0);
    chk("R3 all writes seen", q_addr.size(), 0);
    chk("R4 final src", src_ptr, e_src);
    chk("R4 final dst", dst_ptr, e_dst);
    chk("R5 final count", count_left, e_cnt);
    chk(exp_tc ? "R5 one tc pulse" : "R7/R8 no tc", tc_seen, exp_tc ? 1 : 0);
    repeat (3) @(negedge clk);
    chk("R11 src held", src_ptr, e_src);
    chk("R11 done held", done, 1);
    q_addr.delete(); q_data.delete();
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 hold_req", hold_req, 0);
    chk("R1 strobes", {mem_rd, mem_wr}, 0);
    chk("R1 done/tc", {done, tc}, 0);
    chk("R1 pointers", {src_ptr, dst_ptr}, 0);
    chk("R1 count", count_left, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R9: ascending copy, delayed grant, loads during copy ignored
    run_copy(16'h0010, 16'h0200, 16'd8, 0, 0, 0, 8'h00, 0, 3, 1, 1);
    // R4 both descending
    run_copy(16'h00A0, 16'h02F0, 16'd5, 1, 1, 0, 8'h00, 0, 0, 0, 1);
    // R4 mixed directions
    run_copy(16'h0030, 16'h0260, 16'd4, 0, 1, 0, 8'h00, 0, 1, 0, 1);
    // R8 compare stop on fourth byte
    run_copy(16'h0040, 16'h0280, 16'd10, 0, 0, 1, 8'h43 ^ 8'h5A, 0, 0, 0, 0);
    // R7 external stop during third write
    run_copy(16'h0050, 16'h02A0, 16'd10, 0, 0, 0, 8'h00, 3, 2, 0, 0);

    // R7 stop while awaiting grant
    w0 = wr_seen;
    wr_cfg(3'd0, 16'h0070); wr_cfg(3'd2, 16'd6);
    wr_cfg(3'd4, 16'h0001);
    chk("R7 waiting for grant", hold_req, 1);
    eop_in = 1'b1;
    @(negedge clk);
    eop_in = 1'b0;
    chk("R7 ended in grant wait", done, 1);
    chk("R7 hold dropped", hold_req, 0);
    repeat (3) @(negedge clk);
    chk("R7 no transfer", wr_seen - w0, 0);
    chk("R7 src unchanged", src_ptr, 16'h0070);
    chk("R7 count unchanged", count_left, 6);

    // R10 zero count start
    wr_cfg(3'd2, 16'd0);
    wr_cfg(3'd4, 16'h0001);
    chk("R10 done at once", done, 1);
    chk("R10 no hold_req", hold_req, 0);
    @(negedge clk);
    chk("R10 still no hold_req", hold_req, 0);
    chk("R10 no writes", wr_seen - w0, 0);

    summary();
  end
endmodule